// File: doc/BRIEF.md
# Four-Channel Double-Edge ADC Capture

This block receives the parallel output of a four-channel converter whose channels are all sampled at the same instant. The converter supplies its own clock and changes its data on both edges of that clock. On each rising edge the block takes the upper half of one channel's sample, and on the following falling edge it takes the lower half. It joins the two halves and, guided by a frame marker, collects the four channels into one sample set. Each set is packed into a 64-bit word. The word goes through a Gray-pointer asynchronous FIFO into the system clock domain and leaves on an AXI4-Stream master interface. That interface can feed a DMA engine that writes memory.

Capture is controlled by an enable input and a length. A four-state machine in the converter clock domain has these states. CS_IDLE waits for the synchronized enable. CS_ARM waits for the next frame marker. CS_RUN pushes sets and counts them. CS_HOLD is entered after the final set and stays until the enable falls. The transitions are as follows:
- IDLE→ARM: enable seen.
- ARM→IDLE: enable lost before a frame arrives.
- ARM→RUN: frame marker arrives while enabled; the length is latched.
- RUN→HOLD: the last counted set is pushed.
- HOLD→IDLE: enable low.

If the FIFO is full when a set completes, that set is dropped and a sticky overflow flag is raised.

Top module: `adc_ddr_capture`

## Requirements
- R1: After reset, m_tvalid is 0 and overflow is 0.
- R2: Words leave in the order they were captured. A word is consumed only on a cycle with m_tvalid and m_tready both high. While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values.
- R3: Each converter clock cycle carries one channel sample of 12 bits. The rising-edge half holds sample bits 11:6 and the falling-edge half holds bits 5:0. adc_frame is high during the rising-edge half of channel 0, and channels 1, 2 and 3 follow in the next three cycles.
- R4: Channel k occupies m_tdata[16k+11:16k], and bits 16k+15:16k+12 are zero. Channel 0 sits in the least significant lane.
- R5: While cap_en is low, no word is produced. After cap_en rises, capture starts at the first frame marker, and pairs that arrive before that marker produce nothing.
- R6: If a frame marker arrives before four channels have been collected, the partial set is discarded and collection restarts with that marker as channel 0.
- R7: cap_len is latched when capture starts, and a value of 0 is treated as 1. m_tlast is 1 only on the cap_len-th accepted word. After that word, no further words are produced until cap_en goes low and then high again.
- R8: A set that completes while the FIFO is full is dropped. The sets already stored are delivered intact, and the overflow output goes to 1 and stays there until reset. Dropped sets do not count toward cap_len.
- R9: The clock crossing uses Gray-coded pointers that change by one bit per step. The FIFO holds FIFO_DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | Converter clock; data changes on both edges |
| adc_rst_n | input | 1 | Active-low asynchronous reset, converter domain |
| adc_d | input | 6 | Half-sample data bus |
| adc_frame | input | 1 | High with the rising half of channel 0 |
| sys_clk | input | 1 | System clock for the stream side |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| cap_en | input | 1 | Capture enable, asynchronous, synchronized internally |
| cap_len | input | 16 | Sets per capture; must not change while cap_en is high |
| m_tdata | output | 64 | Four 16-bit lanes, channel 0 lowest |
| m_tvalid | output | 1 | Stream word available |
| m_tready | input | 1 | Downstream accepts the word |
| m_tlast | output | 1 | Final word of a capture |
| overflow | output | 1 | Sticky: a set was dropped because the FIFO was full |

## Verification
The assertions assume three things about the inputs. First, the two clocks are free-running and unrelated. Second, adc_d and adc_frame settle a quarter period before the edge that captures them, and adc_frame is only ever high in the rising half. Third, cap_len stays fixed while cap_en is high. The stimulus keeps within these limits in four ways:
- It generates the converter clock in the same process that drives the data, placing every data change midway between edges.
- It raises the frame marker only in rising halves.
- It changes cap_len only while cap_en is low.
- It drives m_tready from a seeded random source, holding it low on purpose only in the overflow case.

// File: rtl/adcc_pkg.sv
`timescale 1ns/1ps
package adcc_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_ARM  = 2'd1,
        CS_RUN  = 2'd2,
        CS_HOLD = 2'd3
    } cap_state_t;

endpackage

// File: rtl/adcc_ddr_rx.sv
`timescale 1ns/1ps
module adcc_ddr_rx #(
    parameter int HALF_W = 6
) (
    input  logic                  adc_clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     din,
    input  logic                  frm,
    output logic                  pair_v,
    output logic [2*HALF_W-1:0]   pair_data,
    output logic                  pair_frm
);

    logic [HALF_W-1:0] rise_q;
    logic [HALF_W-1:0] fall_q;
    logic              rise_frm_q;
    logic              primed;

    // upper half, taken on the rising edge
    always_ff @(posedge adc_clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q     <= '0;
            rise_frm_q <= 1'b0;
        end else begin
            rise_q     <= din;
            rise_frm_q <= frm;
        end
    end

    // lower half, taken on the falling edge
    always_ff @(negedge adc_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din;
    end

    // join both halves on the next rising edge
    always_ff @(posedge adc_clk or negedge rst_n) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            pair_v    <= 1'b0;
            pair_data <= '0;
            pair_frm  <= 1'b0;
        end else begin
            primed    <= 1'b1;
            pair_v    <= primed;
            pair_data <= {rise_q, fall_q};
            pair_frm  <= rise_frm_q & primed;
        end
    end

endmodule

// File: rtl/adcc_set_asm.sv
`timescale 1ns/1ps
module adcc_set_asm #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 12,
    parameter int LANE_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pair_v,
    input  logic [SAMPLE_W-1:0]        pair_data,
    input  logic                       pair_frm,
    output logic                       set_v,
    output logic [NUM_CH*LANE_W-1:0]   set_data
);

    localparam int SLOT_W = (NUM_CH > 2) ? $clog2(NUM_CH) : 1;
    localparam int PAD_W  = LANE_W - SAMPLE_W;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_CH - 1);

    logic [SAMPLE_W-1:0] lane_q [NUM_CH];
    logic [SLOT_W-1:0]   slot;
    logic                aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CH; k++) lane_q[k] <= '0;
            slot    <= '0;
            aligned <= 1'b0;
            set_v   <= 1'b0;
        end else begin
            set_v <= 1'b0;
            if (pair_v) begin
                if (pair_frm) begin
                    // a marker always restarts the set at channel 0
                    lane_q[0] <= pair_data;
                    slot      <= SLOT_W'(1);
                    aligned   <= 1'b1;
                end else if (aligned) begin
                    lane_q[slot] <= pair_data;
                    if (slot == SLOT_LAST) begin
                        aligned <= 1'b0;
                        set_v   <= 1'b1;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        if (PAD_W > 0) begin : g_pad
            assign set_data[k*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, lane_q[k]};
        end else begin : g_nopad
            assign set_data[k*LANE_W +: LANE_W] = lane_q[k];
        end
    end

    // R6: a marker pair starts a set, so it can never complete one
    a_r6_marker_no_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_v && pair_frm) |=> !set_v);

endmodule

// File: rtl/adcc_capture_fsm.sv
`timescale 1ns/1ps
module adcc_capture_fsm
    import adcc_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              frame_seen,
    input  logic              set_v,
    input  logic [DATA_W-1:0] set_data,
    input  logic [LEN_W-1:0]  cap_len,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W:0]   push_word,
    output logic              ovf
);

    cap_state_t       state, nxt;
    logic [LEN_W-1:0] count;
    logic [LEN_W-1:0] len_q;
    logic             is_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE: if (en_s) nxt = CS_ARM;
            CS_ARM: begin
                if (!en_s)           nxt = CS_IDLE;
                else if (frame_seen) nxt = CS_RUN;
            end
            CS_RUN:  if (set_v && !fifo_full && is_last) nxt = CS_HOLD;
            CS_HOLD: if (!en_s) nxt = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_last   = (count == LEN_W'(len_q - LEN_W'(1)));
        push      = (state == CS_RUN) && set_v && !fifo_full;
        push_word = {is_last, set_data};
    end

    // length bookkeeping and sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            len_q <= LEN_W'(1);
            ovf   <= 1'b0;
        end else begin
            if (state == CS_ARM && en_s && frame_seen) begin
                count <= '0;
                len_q <= (cap_len == '0) ? LEN_W'(1) : cap_len;
            end else if (push) begin
                count <= count + LEN_W'(1);
            end
            if (state == CS_RUN && set_v && fifo_full) ovf <= 1'b1;
        end
    end

    // R7: pushing the last word ends the run
    a_r7_last_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[DATA_W]) |=> (state == CS_HOLD));

    // R8: overflow never clears
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R5: capture only opens on a frame boundary
    a_r5_run_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_ARM && !frame_seen) |=> (state != CS_RUN));

endmodule

// File: rtl/adcc_async_fifo.sv
`timescale 1ns/1ps
module adcc_async_fifo #(
    parameter int WIDTH = 65,
    parameter int DEPTH = 8
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);

    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] wq1, wq2;   // read pointer seen in write domain
    logic [AW:0] rq1, rq2;   // write pointer seen in read domain
    logic [AW:0] wbin_nx, rbin_nx;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    assign wbin_nx = wbin + (AW+1)'(1);
    assign rbin_nx = rbin + (AW+1)'(1);

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin <= '0; wgray <= '0; wq1 <= '0; wq2 <= '0;
        end else begin
            wq1 <= rgray;
            wq2 <= wq1;
            if (wr_en && !full) begin
                wbin  <= wbin_nx;
                wgray <= to_gray(wbin_nx);
            end
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin <= '0; rgray <= '0; rq1 <= '0; rq2 <= '0;
        end else begin
            rq1 <= wgray;
            rq2 <= rq1;
            if (rd_en && !empty) begin
                rbin  <= rbin_nx;
                rgray <= to_gray(rbin_nx);
            end
        end
    end

    assign full  = (wgray == {~wq2[AW:AW-1], wq2[AW-2:0]});
    assign empty = (rgray == rq2);
    assign rdata = mem[rbin[AW-1:0]];

    // R9: each pointer moves by a single Gray bit
    a_r9_wgray_one_bit: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wgray != $past(wgray)) |-> ($countones(wgray ^ $past(wgray)) == 1));

    a_r9_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rgray != $past(rgray)) |-> ($countones(rgray ^ $past(rgray)) == 1));

endmodule

// File: rtl/adc_ddr_capture.sv
`timescale 1ns/1ps
module adc_ddr_capture
    import adcc_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int NUM_CH     = 4,
    parameter int LANE_W     = 16,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                       adc_clk,
    input  logic                       adc_rst_n,
    input  logic [SAMPLE_W/2-1:0]      adc_d,
    input  logic                       adc_frame,
    input  logic                       sys_clk,
    input  logic                       sys_rst_n,
    input  logic                       cap_en,
    input  logic [LEN_W-1:0]           cap_len,
    output logic [NUM_CH*LANE_W-1:0]   m_tdata,
    output logic                       m_tvalid,
    input  logic                       m_tready,
    output logic                       m_tlast,
    output logic                       overflow
);

    localparam int HALF_W = SAMPLE_W / 2;
    localparam int DATA_W = NUM_CH * LANE_W;

    logic                pair_v, pair_frm;
    logic [SAMPLE_W-1:0] pair_data;
    logic                set_v;
    logic [DATA_W-1:0]   set_data;
    logic                en_q1, en_s;
    logic                push, fifo_full, fifo_empty, ovf_adc;
    logic [DATA_W:0]     push_word, pop_word;
    logic                ovf_q1, ovf_q2;

    // enable into the converter domain
    always_ff @(posedge adc_clk or negedge adc_rst_n) begin
        if (!adc_rst_n) begin
            en_q1 <= 1'b0;
            en_s  <= 1'b0;
        end else begin
            en_q1 <= cap_en;
            en_s  <= en_q1;
        end
    end

    adcc_ddr_rx #(.HALF_W(HALF_W)) u_rx (
        .adc_clk   (adc_clk),
        .rst_n     (adc_rst_n),
        .din       (adc_d),
        .frm       (adc_frame),
        .pair_v    (pair_v),
        .pair_data (pair_data),
        .pair_frm  (pair_frm)
    );

    adcc_set_asm #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .LANE_W(LANE_W)) u_asm (
        .clk       (adc_clk),
        .rst_n     (adc_rst_n),
        .pair_v    (pair_v),
        .pair_data (pair_data),
        .pair_frm  (pair_frm),
        .set_v     (set_v),
        .set_data  (set_data)
    );

    adcc_capture_fsm #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (adc_clk),
        .rst_n      (adc_rst_n),
        .en_s       (en_s),
        .frame_seen (pair_v & pair_frm),
        .set_v      (set_v),
        .set_data   (set_data),
        .cap_len    (cap_len),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_word  (push_word),
        .ovf        (ovf_adc)
    );

    adcc_async_fifo #(.WIDTH(DATA_W+1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .wclk   (adc_clk),
        .wrst_n (adc_rst_n),
        .wr_en  (push),
        .wdata  (push_word),
        .full   (fifo_full),
        .rclk   (sys_clk),
        .rrst_n (sys_rst_n),
        .rd_en  (m_tvalid & m_tready),
        .rdata  (pop_word),
        .empty  (fifo_empty)
    );

    // sticky flag into the system domain
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            ovf_q1 <= 1'b0;
            ovf_q2 <= 1'b0;
        end else begin
            ovf_q1 <= ovf_adc;
            ovf_q2 <= ovf_q1;
        end
    end

    assign overflow = ovf_q2;
    assign m_tvalid = !fifo_empty;
    assign m_tdata  = pop_word[DATA_W-1:0];
    assign m_tlast  = pop_word[DATA_W];

    // R2: a stalled word is held unchanged
    a_r2_stall_stable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

// File: tb/sim_adc_ddr_capture.sv
`timescale 1ns/1ps
module sim_adc_ddr_capture;

    localparam int DEPTH = 8;

    logic        adc_clk, adc_rst_n, adc_frame;
    logic [5:0]  adc_d;
    logic        sys_clk = 1'b0;
    logic        sys_rst_n, cap_en;
    logic [15:0] cap_len;
    logic [63:0] m_tdata;
    logic        m_tvalid, m_tready, m_tlast, overflow;

    int errors = 0;
    int checks = 0;
    bit hold_ready = 1'b0;
    bit done = 1'b0;

    logic [12:0] pq[$];        // {frame, sample}
    logic [64:0] exp_q[$];     // {last, data}
    logic [64:0] got_q[$];

    adc_ddr_capture #(.FIFO_DEPTH(DEPTH)) u0 (
        .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .adc_d(adc_d), .adc_frame(adc_frame),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cap_en(cap_en), .cap_len(cap_len),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .overflow(overflow)
    );

    always #10 sys_clk = ~sys_clk;

    // converter model: clock and data from one process, data a quarter period ahead of each edge
    initial begin
        logic [12:0] e;
        adc_clk = 1'b0; adc_d = '0; adc_frame = 1'b0;
        forever begin
            e = 13'h0;
            if (pq.size() > 0) e = pq.pop_front();
            adc_d = e[11:6]; adc_frame = e[12];
            #9 adc_clk = 1'b1;
            #9 adc_d = e[5:0]; adc_frame = 1'b0;
            #9 adc_clk = 1'b0;
            #9;
        end
    end

    // stream sink: decide tready for the next edge and record the handshake it makes
    initial begin
        m_tready = 1'b0;
        forever begin
            @(posedge sys_clk);
            #5;
            m_tready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
            if (m_tvalid && m_tready) got_q.push_back({m_tlast, m_tdata});
        end
    end

    function automatic logic [63:0] pack4(input logic [11:0] a, b, c, d);
        return {4'h0, d, 4'h0, c, 4'h0, b, 4'h0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_set(input bit expect_it, input bit last);
        logic [11:0] s [4];
        for (int k = 0; k < 4; k++) begin
            s[k] = 12'($urandom);
            pq.push_back({(k == 0), s[k]});
        end
        if (expect_it) exp_q.push_back({last, pack4(s[0], s[1], s[2], s[3])});
    endtask

    task automatic send_junk(input int n);
        for (int k = 0; k < n; k++) pq.push_back({1'b0, 12'($urandom)});
    endtask

    task automatic send_partial(input int n);
        for (int k = 0; k < n; k++) pq.push_back({(k == 0), 12'($urandom)});
    endtask

    task automatic settle();
        while (pq.size() != 0) @(posedge sys_clk);
        repeat (80) @(posedge sys_clk);
    endtask

    task automatic rearm(input logic [15:0] len);
        cap_en = 1'b0;
        repeat (20) @(posedge sys_clk);
        cap_len = len;
        cap_en  = 1'b1;
        repeat (20) @(posedge sys_clk);
    endtask

    task automatic compare(input string req);
        chk(got_q.size() == exp_q.size(), req, 65'(got_q.size()), 65'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        void'($urandom(32'd4051));
        adc_rst_n = 1'b0; sys_rst_n = 1'b0; cap_en = 1'b0; cap_len = '0;
        repeat (5) @(posedge sys_clk);
        adc_rst_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge sys_clk);
        // R1 reset state
        chk(m_tvalid == 1'b0, "R1 tvalid", 65'(m_tvalid), 65'd0);
        chk(overflow == 1'b0, "R1 overflow", 65'(overflow), 65'd0);

        // R5 R3 R4 R7: junk before the marker, five sets, two extra sets ignored
        rearm(16'd5);
        send_junk(3);
        for (int i = 0; i < 5; i++) send_set(1'b1, i == 4);
        send_set(1'b0, 1'b0);
        send_set(1'b0, 1'b0);
        settle();
        compare("R3 R4 R5 R7");
        @(negedge sys_clk);
        chk(m_tvalid == 1'b0, "R7 nothing after last", 65'(m_tvalid), 65'd0);

        // R7 zero length acts as one
        rearm(16'd0);
        send_set(1'b1, 1'b1);
        send_set(1'b0, 1'b0);
        settle();
        compare("R7 zero length");

        // R6 partial sets discarded
        rearm(16'd3);
        send_partial(3);
        send_set(1'b1, 1'b0);
        send_partial(2);
        send_set(1'b1, 1'b0);
        send_set(1'b1, 1'b1);
        settle();
        compare("R6");

        // R5 enable low blocks capture
        cap_en = 1'b0;
        repeat (20) @(posedge sys_clk);
        for (int i = 0; i < 3; i++) send_set(1'b0, 1'b0);
        settle();
        compare("R5 disabled");

        // R2 R9 random lengths with random backpressure
        for (int r = 0; r < 4; r++) begin
            int n;
            n = 1 + ($urandom % 6);
            rearm(16'(n));
            send_junk($urandom % 3);
            for (int i = 0; i < n; i++) send_set(1'b1, i == n - 1);
            send_set(1'b0, 1'b0);
            settle();
            compare("R2 R9 random");
        end

        // R8 overflow: stall the sink, overfill, then drain
        @(negedge sys_clk);
        chk(overflow == 1'b0, "R8 before", 65'(overflow), 65'd0);
        hold_ready = 1'b1;
        rearm(16'(DEPTH + 2));
        for (int i = 0; i < DEPTH + 3; i++) send_set(i < DEPTH, 1'b0);
        while (pq.size() != 0) @(posedge sys_clk);
        repeat (40) @(posedge sys_clk);
        @(negedge sys_clk);
        chk(overflow == 1'b1, "R8 flag", 65'(overflow), 65'd1);
        chk(got_q.size() == 0, "R8 stalled", 65'(got_q.size()), 65'd0);
        hold_ready = 1'b0;
        settle();
        compare("R8 stored sets");
        send_set(1'b1, 1'b0);
        send_set(1'b1, 1'b1);
        settle();
        compare("R8 dropped not counted");
        @(negedge sys_clk);
        chk(overflow == 1'b1, "R8 sticky", 65'(overflow), 65'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule